// File: doc/BRIEF.md
# Virtual Address Translation Unit

The unit turns the virtual address of one load or store into a physical address in the same cycle that the access is presented. It first checks the alignment of the access against its width, then whether the access is privileged. An access that passes both checks either falls into the directly mapped top quarter of the address space or is translated through a fully associative page table cache. That cache sits outside the unit. The unit drives the page number out on a lookup port and receives the hit, valid, write-enable and frame fields of the matching entry.

Every fault produces a single one-hot exception code, chosen by a fixed priority. On the following clock edge the unit records the faulting address and a descriptor of the access. Faults that come from the translation itself also record the faulting page number, so that software can refill the cache. Each access that gets past the privilege check pulses a strobe, which the replacement pointer of the cache uses to step forward.

Pages are 4 KiB: the page number is bits [31:12] and the offset is bits [11:0]. The translation is combinational. Only the fault records are clocked.

Top module: `vaddr_xlate`

## Requirements
- R1: When `acc_valid` is high, a misaligned access sets `exc_code` to 5'b00001, ahead of every other fault. An access is misaligned if it is a word access (`acc_width`=2) with `acc_vaddr[1:0]` nonzero, or a half access (`acc_width`=1) with `acc_vaddr[0]`=1. A byte access (`acc_width`=0) is never misaligned.
- R2: An aligned user-mode access (`acc_user`=1) with `acc_vaddr[31]`=1 sets `exc_code` to 5'b00010.
- R3: An aligned access with `acc_vaddr[31:30]`=2'b11 that is not privilege-faulted gives `exc_code`=0 and `pa_out` = `acc_vaddr` with bits 31:30 cleared. The lookup inputs have no effect on such an access.
- R4: Any other aligned, permitted access with `lk_hit`=0 sets `exc_code` to 5'b00100 (miss).
- R5: The same access with `lk_hit`=1 and `lk_valid`=0 sets `exc_code` to 5'b01000 (invalid), even if it is a write to a write-protected entry.
- R6: The same access with `lk_hit`=1, `lk_valid`=1, `acc_write`=1 and `lk_wen`=0 sets `exc_code` to 5'b10000. A read of a write-protected entry does not fault.
- R7: A mapped access without a fault gives `pa_out` = {`lk_frame`, `acc_vaddr[11:0]`}. `lk_page` always equals `acc_vaddr[31:12]`.
- R8: At the clock edge after a faulting access, `bad_addr` takes `acc_vaddr` and `bad_accs` takes {`acc_write`, `acc_width`} (bit 2 is the write flag). At any other edge both registers hold their value.
- R9: `fault_page` takes `acc_vaddr[31:12]` at the edge after a miss, invalid or write fault. It holds its value after alignment faults, privilege faults and access without a fault.
- R10: `rand_step` is high in the same cycle as every valid access that passes the alignment and privilege checks. This includes unmapped accesses and accesses that fault in the TLB. It is low otherwise.
- R11: After reset, `bad_addr`, `bad_accs` and `fault_page` are zero. While `acc_valid`=0, `exc_code` is zero and `rand_step` is low. `exc_code` never has more than one bit set.
- R12: `pa_out` is zero whenever `exc_code` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_vaddr | input | 32 | Virtual address |
| acc_user | input | 1 | Access issued in user mode |
| acc_write | input | 1 | Access is a store |
| acc_width | input | 2 | 0 byte, 1 half, 2 word |
| lk_page | output | 20 | Page number sent to the external lookup |
| lk_hit | input | 1 | Lookup found a matching entry |
| lk_valid | input | 1 | Valid bit of the matching entry |
| lk_wen | input | 1 | Write-enable bit of the matching entry |
| lk_frame | input | 20 | Frame number of the matching entry |
| pa_out | output | 32 | Physical address, zero on a fault |
| exc_code | output | 5 | One-hot fault: bit0 align, bit1 privilege, bit2 miss, bit3 invalid, bit4 write |
| bad_addr | output | 32 | Address of the most recent fault |
| bad_accs | output | 3 | {write, width} of the most recent fault |
| fault_page | output | 20 | Page number of the most recent TLB fault |
| rand_step | output | 1 | Advance strobe for the replacement pointer |

## Verification
The assertions assume that `acc_width` never carries the unused code 3. They also assume that the lookup inputs answer the page on `lk_page` within the same cycle, because they compare `pa_out` directly against `lk_frame`. The stimulus drives only the three defined width codes, and it changes the address and the lookup answer together on the falling clock edge. Lookup fields are treated as meaningful only when `lk_hit` is high, so the checks on the invalid and write faults always present a hit. For unmapped addresses the stimulus deliberately offers a miss, which shows that the answer is ignored.

// File: rtl/vxl_pkg.sv
package vxl_pkg;

  typedef enum logic [1:0] {
    AW_BYTE = 2'd0,
    AW_HALF = 2'd1,
    AW_WORD = 2'd2,
    AW_RSVD = 2'd3
  } acc_width_e;

  localparam int EXC_N     = 5;
  localparam int EB_ALIGN  = 0;
  localparam int EB_PRIV   = 1;
  localparam int EB_MISS   = 2;
  localparam int EB_INVAL  = 3;
  localparam int EB_WPROT  = 4;

  // Alignment rule: the low address bits must be clear up to the access size.
  function automatic logic misaligned(input logic [1:0] low, input logic [1:0] width);
    logic r;
    case (acc_width_e'(width))
      AW_BYTE: r = 1'b0;
      AW_HALF: r = low[0];
      default: r = |low;
    endcase
    return r;
  endfunction

  // Keep only the lowest-numbered raised fault: bit order is priority order.
  function automatic logic [EXC_N-1:0] prio_pick(input logic [EXC_N-1:0] raw);
    logic [EXC_N-1:0] r;
    logic found;
    r = '0;
    found = 1'b0;
    for (int i = 0; i < EXC_N; i++) begin
      if (raw[i] && !found) begin
        r[i] = 1'b1;
        found = 1'b1;
      end
    end
    return r;
  endfunction

  // Direct-mapped region: top two address bits both set.
  function automatic logic is_direct(input logic [1:0] top);
    return top == 2'b11;
  endfunction

endpackage

// File: rtl/vxl_gate.sv
module vxl_gate (
  input  logic       valid,
  input  logic [1:0] addr_low,
  input  logic       addr_msb,
  input  logic       user,
  input  logic [1:0] width,
  output logic       align_flt,
  output logic       priv_flt,
  output logic       passed
);
  import vxl_pkg::*;

  always_comb begin
    align_flt = valid && misaligned(addr_low, width);
    priv_flt  = valid && !align_flt && user && addr_msb;
    passed    = valid && !align_flt && !priv_flt;
  end
endmodule

// File: rtl/vxl_region.sv
module vxl_region #(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12,
  localparam int VPN_W = VA_W - OFF_W
) (
  input  logic [VA_W-1:0]  vaddr,
  input  logic             write,
  input  logic             lk_hit,
  input  logic             lk_valid,
  input  logic             lk_wen,
  input  logic [VPN_W-1:0] lk_frame,
  output logic             direct,
  output logic             miss,
  output logic             inval,
  output logic             wprot,
  output logic [VA_W-1:0]  pa
);
  import vxl_pkg::*;

  always_comb begin
    direct = is_direct(vaddr[VA_W-1:VA_W-2]);
    miss   = !direct && !lk_hit;
    inval  = !direct && lk_hit && !lk_valid;
    wprot  = !direct && lk_hit && lk_valid && write && !lk_wen;
    if (direct) pa = {2'b00, vaddr[VA_W-3:0]};
    else        pa = {lk_frame, vaddr[OFF_W-1:0]};
  end
endmodule

// File: rtl/vxl_fault_regs.sv
module vxl_fault_regs #(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12,
  localparam int VPN_W = VA_W - OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             any_fault,
  input  logic             tlb_fault,
  input  logic [VA_W-1:0]  vaddr,
  input  logic [2:0]       accs,
  output logic [VA_W-1:0]  bad_addr,
  output logic [2:0]       bad_accs,
  output logic [VPN_W-1:0] fault_page
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bad_addr   <= '0;
      bad_accs   <= '0;
      fault_page <= '0;
    end else begin
      if (any_fault) begin
        bad_addr <= vaddr;
        bad_accs <= accs;
      end
      if (tlb_fault) fault_page <= vaddr[VA_W-1:OFF_W];
    end
  end
endmodule

// File: rtl/vaddr_xlate.sv
module vaddr_xlate #(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12,
  localparam int VPN_W = VA_W - OFF_W,
  localparam int EXC_W = vxl_pkg::EXC_N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic [VA_W-1:0]  acc_vaddr,
  input  logic             acc_user,
  input  logic             acc_write,
  input  logic [1:0]       acc_width,
  output logic [VPN_W-1:0] lk_page,
  input  logic             lk_hit,
  input  logic             lk_valid,
  input  logic             lk_wen,
  input  logic [VPN_W-1:0] lk_frame,
  output logic [VA_W-1:0]  pa_out,
  output logic [EXC_W-1:0] exc_code,
  output logic [VA_W-1:0]  bad_addr,
  output logic [2:0]       bad_accs,
  output logic [VPN_W-1:0] fault_page,
  output logic             rand_step
);
  import vxl_pkg::*;

  // Named internal events, visible to the bound checker.
  logic            ev_align, ev_priv, ev_pass;
  logic            ev_direct, ev_miss, ev_inval, ev_wprot;
  logic [VA_W-1:0] xl_pa;
  logic [EXC_W-1:0] raw_exc;
  logic            ev_fault, ev_tlb_fault;

  vxl_gate u_gate (
    .valid     (acc_valid),
    .addr_low  (acc_vaddr[1:0]),
    .addr_msb  (acc_vaddr[VA_W-1]),
    .user      (acc_user),
    .width     (acc_width),
    .align_flt (ev_align),
    .priv_flt  (ev_priv),
    .passed    (ev_pass)
  );

  vxl_region #(.VA_W(VA_W), .OFF_W(OFF_W)) u_region (
    .vaddr    (acc_vaddr),
    .write    (acc_write),
    .lk_hit   (lk_hit),
    .lk_valid (lk_valid),
    .lk_wen   (lk_wen),
    .lk_frame (lk_frame),
    .direct   (ev_direct),
    .miss     (ev_miss),
    .inval    (ev_inval),
    .wprot    (ev_wprot),
    .pa       (xl_pa)
  );

  always_comb begin
    raw_exc           = '0;
    raw_exc[EB_ALIGN] = ev_align;
    raw_exc[EB_PRIV]  = ev_priv;
    raw_exc[EB_MISS]  = acc_valid && ev_miss;
    raw_exc[EB_INVAL] = acc_valid && ev_inval;
    raw_exc[EB_WPROT] = acc_valid && ev_wprot;
    exc_code          = prio_pick(raw_exc);
    ev_fault          = |exc_code;
    ev_tlb_fault      = exc_code[EB_MISS] | exc_code[EB_INVAL] | exc_code[EB_WPROT];
    pa_out            = (acc_valid && !ev_fault) ? xl_pa : '0;
    lk_page           = acc_vaddr[VA_W-1:OFF_W];
    rand_step         = ev_pass;
  end

  vxl_fault_regs #(.VA_W(VA_W), .OFF_W(OFF_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .any_fault  (ev_fault),
    .tlb_fault  (ev_tlb_fault),
    .vaddr      (acc_vaddr),
    .accs       ({acc_write, acc_width}),
    .bad_addr   (bad_addr),
    .bad_accs   (bad_accs),
    .fault_page (fault_page)
  );
endmodule

// File: rtl/vxl_checker.sv
module vxl_checker #(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12,
  localparam int VPN_W = VA_W - OFF_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_valid,
  input logic [VA_W-1:0]  acc_vaddr,
  input logic             acc_user,
  input logic             acc_write,
  input logic [1:0]       acc_width,
  input logic             lk_hit,
  input logic [VPN_W-1:0] lk_frame,
  input logic [VA_W-1:0]  pa_out,
  input logic [4:0]       exc_code,
  input logic [VA_W-1:0]  bad_addr,
  input logic [2:0]       bad_accs,
  input logic [VPN_W-1:0] fault_page,
  input logic             rand_step
);
  logic mis_in;
  assign mis_in = (acc_width == 2'd1) ? acc_vaddr[0] :
                  (acc_width == 2'd0) ? 1'b0 : (acc_vaddr[1:0] != 2'b00);

  assert_align_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && mis_in |-> exc_code == 5'b00001);

  assert_user_priv_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !mis_in && acc_user && acc_vaddr[VA_W-1] |-> exc_code == 5'b00010);

  assert_direct_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !mis_in && !acc_user && acc_vaddr[VA_W-1:VA_W-2] == 2'b11
    |-> exc_code == 5'b0 && pa_out == {2'b00, acc_vaddr[VA_W-3:0]});

  assert_miss_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !mis_in && !acc_vaddr[VA_W-1] && !lk_hit |-> exc_code == 5'b00100);

  assert_mapped_pa_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && exc_code == 5'b0 && acc_vaddr[VA_W-1:VA_W-2] != 2'b11
    |-> pa_out == {lk_frame, acc_vaddr[OFF_W-1:0]});

  assert_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && exc_code != 5'b0 |=> bad_addr == $past(acc_vaddr)
      && bad_accs == {$past(acc_write), $past(acc_width)});

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && exc_code != 5'b0) |=> $stable(bad_addr) && $stable(bad_accs));

  assert_page_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    exc_code[4:2] == 3'b000 |=> $stable(fault_page));

  assert_step_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rand_step |-> acc_valid && exc_code[1:0] == 2'b00);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> exc_code == 5'b0 && !rand_step);

  assert_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(exc_code));

  assert_pa_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    exc_code != 5'b0 |-> pa_out == '0);
endmodule

bind vaddr_xlate vxl_checker #(.VA_W(VA_W), .OFF_W(OFF_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_valid  (acc_valid),
  .acc_vaddr  (acc_vaddr),
  .acc_user   (acc_user),
  .acc_write  (acc_write),
  .acc_width  (acc_width),
  .lk_hit     (lk_hit),
  .lk_frame   (lk_frame),
  .pa_out     (pa_out),
  .exc_code   (exc_code),
  .bad_addr   (bad_addr),
  .bad_accs   (bad_accs),
  .fault_page (fault_page),
  .rand_step  (rand_step)
);

// File: tb/tb_vaddr_xlate.sv
`timescale 1ns/1ps
module tb_vaddr_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_vaddr = '0;
  logic        acc_user = 1'b0;
  logic        acc_write = 1'b0;
  logic [1:0]  acc_width = 2'd0;
  logic [19:0] lk_page;
  logic        lk_hit = 1'b0;
  logic        lk_valid = 1'b0;
  logic        lk_wen = 1'b0;
  logic [19:0] lk_frame = '0;
  logic [31:0] pa_out;
  logic [4:0]  exc_code;
  logic [31:0] bad_addr;
  logic [2:0]  bad_accs;
  logic [19:0] fault_page;
  logic        rand_step;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Bench-side shadow of the fault records.
  logic [31:0] m_bad_addr = '0;
  logic [2:0]  m_bad_accs = '0;
  logic [19:0] m_page = '0;

  always #2.5 clk = ~clk;

  vaddr_xlate dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_vaddr(acc_vaddr),
    .acc_user(acc_user), .acc_write(acc_write), .acc_width(acc_width),
    .lk_page(lk_page), .lk_hit(lk_hit), .lk_valid(lk_valid), .lk_wen(lk_wen),
    .lk_frame(lk_frame), .pa_out(pa_out), .exc_code(exc_code),
    .bad_addr(bad_addr), .bad_accs(bad_accs), .fault_page(fault_page),
    .rand_step(rand_step)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One access: expected results worked out from the requirement text.
  task automatic access(input string tag, input logic [31:0] va, input logic user,
                        input logic wr, input logic [1:0] w, input logic hit,
                        input logic vld, input logic wen, input logic [19:0] frame);
    logic [4:0]  e;
    logic [31:0] pa;
    logic        bad_align, bad_priv;
    @(negedge clk);
    acc_valid = 1'b1; acc_vaddr = va; acc_user = user; acc_write = wr;
    acc_width = w; lk_hit = hit; lk_valid = vld; lk_wen = wen; lk_frame = frame;
    bad_align = (w == 2'd2 && va[1:0] != 2'b00) || (w == 2'd1 && va[0]);
    bad_priv  = !bad_align && user && va[31];
    pa = 32'h0;
    if (bad_align)                e = 5'd1;
    else if (bad_priv)            e = 5'd2;
    else if (va[31:30] == 2'b11) begin e = 5'd0; pa = va & 32'h3FFF_FFFF; end
    else if (!hit)                e = 5'd4;
    else if (!vld)                e = 5'd8;
    else if (wr && !wen)          e = 5'd16;
    else begin e = 5'd0; pa = {frame, va[11:0]}; end
    #1;
    check({tag, " exc"}, {27'd0, exc_code}, {27'd0, e});
    check({tag, " pa"}, pa_out, pa);
    check({tag, " step R10"}, {31'd0, rand_step}, {31'd0, !bad_align && !bad_priv});
    check({tag, " page R7"}, {12'd0, lk_page}, {12'd0, va[31:12]});
    if (e != 5'd0) begin m_bad_addr = va; m_bad_accs = {wr, w}; end
    if (e >= 5'd4) m_page = va[31:12];
    @(posedge clk); #1;
    acc_valid = 1'b0;
    check({tag, " bad_addr R8"}, bad_addr, m_bad_addr);
    check({tag, " bad_accs R8"}, {29'd0, bad_accs}, {29'd0, m_bad_accs});
    check({tag, " fault_page R9"}, {12'd0, fault_page}, {12'd0, m_page});
  endtask

  task automatic t_reset;
    #1;
    check("R11 reset bad_addr", bad_addr, 32'h0);
    check("R11 reset bad_accs", {29'd0, bad_accs}, 32'h0);
    check("R11 reset fault_page", {12'd0, fault_page}, 32'h0);
    check("R11 idle exc", {27'd0, exc_code}, 32'h0);
    check("R11 idle step", {31'd0, rand_step}, 32'h0);
  endtask

  task automatic t_align;
    access("R1 word off2", 32'h0000_1002, 0, 0, 2'd2, 1, 1, 1, 20'h00AAA);
    access("R1 half odd write", 32'h0040_0011, 0, 1, 2'd1, 1, 1, 1, 20'h00BBB);
    access("R1 byte odd ok", 32'h0040_0013, 0, 0, 2'd0, 1, 1, 1, 20'h12345);
    access("R1 over priv", 32'h8000_0003, 1, 0, 2'd2, 0, 0, 0, 20'h0);
    access("R1 word in direct", 32'hC000_0001, 0, 1, 2'd2, 1, 1, 1, 20'h0);
  endtask

  task automatic t_priv;
    access("R2 user kernel mapped", 32'h8000_2000, 1, 0, 2'd2, 1, 1, 1, 20'h00001);
    access("R2 user direct", 32'hC000_1000, 1, 1, 2'd0, 1, 1, 1, 20'h0);
    access("R2 kernel mapped ok", 32'h8000_3004, 0, 0, 2'd2, 1, 1, 0, 20'h00777);
  endtask

  task automatic t_direct;
    access("R3 direct miss ignored", 32'hC123_4568, 0, 1, 2'd2, 0, 0, 0, 20'hFFFFF);
    access("R3 direct top", 32'hFFFF_FFFF, 0, 0, 2'd0, 1, 0, 0, 20'h0);
  endtask

  task automatic t_tlb;
    access("R4 miss", 32'h1234_5678, 0, 0, 2'd2, 0, 1, 1, 20'h55555);
    access("R5 invalid over wprot", 32'h2000_4000, 1, 1, 2'd2, 1, 0, 0, 20'h11111);
    access("R6 write prot", 32'h0000_5006, 0, 1, 2'd1, 1, 1, 0, 20'h22222);
    access("R6 read prot ok", 32'h0000_5006, 0, 0, 2'd1, 1, 1, 0, 20'h22222);
    access("R7 mapped write", 32'h7654_3ABC, 1, 1, 2'd2, 1, 1, 1, 20'hABCDE);
  endtask

  task automatic t_hold;
    // A clean access after a TLB fault leaves all records unchanged.
    access("R9 record", 32'h0BAD_0000, 0, 0, 2'd0, 0, 0, 0, 20'h0);
    access("R8 align keeps page", 32'h0C00_0002, 0, 0, 2'd2, 0, 0, 0, 20'h0);
    access("R8 clean", 32'h0001_0000, 0, 0, 2'd0, 1, 1, 1, 20'h00042);
    @(negedge clk); #1;
    check("R11 idle after access exc", {27'd0, exc_code}, 32'h0);
    check("R11 idle after access step", {31'd0, rand_step}, 32'h0);
    check("R12 idle pa", pa_out, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_align();
    t_priv();
    t_direct();
    t_tlb();
    t_hold();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule